// File: doc/BRIEF.md
# Serial Register-Access Target for a Real-Time Clock

This block connects a four-wire serial host bus to the sixteen 8-bit registers of a real-time clock core. The host raises the chip select and sends a command byte. Bit 4 of that byte marks a valid access, bit 7 picks read (set) or write (clear), and the low nibble is the first register number. Any number of data bytes can follow. Each data byte moves to the next register, and the address wraps from 15 back to 0.

The clock core is reached through a plain parallel port. The port carries an address, write data, a one-cycle write strobe and a one-cycle read strobe. The core must return the read data on `reg_rdata` one clock after the read strobe, as a registered (block-RAM style) read does.

The serial pins are sampled by the system clock through synchronisers. The serial clock must therefore run well below the system clock: each half period must last at least six system clocks. The bus uses mode 0. The target samples MOSI on the rising serial clock edge and changes MISO on the falling edge, most significant bit first.

Top module: `rtc_spi_target`

## Requirements
- R1: The chip select is active high. While it is low, serial clock edges have no effect. No strobe is issued and no bits are collected.
- R2: The first byte after the chip select rises is the command. It is valid when bit 4 is 1. Bit 7 = 1 selects read and bit 7 = 0 selects write. Bits 3:0 give the start register (0 to 15).
- R3: In a valid write, each complete data byte produces exactly one `reg_we` pulse. The pulse carries that byte on `reg_wdata` and the current register on `reg_addr`. The register steps up by one for each byte, starting at the commanded register.
- R4: In a valid read, the target pulses `reg_re` for the current register and loads the returned byte. MISO presents that byte MSB first, changing on falling serial clock edges. The first data byte comes from the commanded register and each later byte from the next register.
- R5: During a burst, the register number wraps from 15 to 0.
- R6: A command byte with bit 4 clear is ignored. The data bytes that follow it cause no `reg_we` or `reg_re` pulse, and MISO stays 0 until the chip select drops.
- R7: Dropping the chip select part-way through a byte discards the partial byte and causes no strobe. The next transaction starts again with a command byte.
- R8: After synchronous reset, MISO, `reg_we` and `reg_re` are all 0.
- R9: MISO is 0 during the command byte, during write data, during an ignored transaction and while the chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 4 | Register number for the current access |
| reg_wdata | output | 8 | Write data to the clock core |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data from the clock core, valid one cycle after `reg_re` |

## Verification
The bench runs bursts of 7 bytes from register 2 and 4 bytes from register 9. It also runs a full 16-byte read and bursts that cross from register 15 to 0. These would show a target that saturates the address instead of wrapping, or that fetches the first byte one register late.

Commands with bit 4 clear, including one with bit 7 set, must leave the clock core untouched and MISO silent. A decoder that looked only at bit 7 would write or read there.

Chip select is dropped after part of a data byte and after part of a command byte. A target that kept its bit count would misframe the next command. One that kept the partial byte would issue a stray write.

Serial clock pulses sent while the chip select is low must produce no strobe.

// File: rtl/rtc_spi_pkg.sv
`timescale 1ns/1ps
package rtc_spi_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int CMD_VALID  = 4;  // access-marker bit in the command byte
  localparam int CMD_READ   = 7;  // read/write select bit
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_SKIP} phase_t;
endpackage

// File: rtl/rtc_spi_sync.sv
`timescale 1ns/1ps
module rtc_spi_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/rtc_spi_shifter.sv
`timescale 1ns/1ps
module rtc_spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_lvl,
  input  logic         sck_lvl,
  input  logic         mosi_lvl,
  input  logic         tx_load,
  input  logic [W-1:0] tx_data,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         miso
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             sck_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     rx_sh, tx_sh;
  logic             sck_rise, sck_fall;

  assign sck_rise = sck_lvl & ~sck_q;
  assign sck_fall = ~sck_lvl & sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_lvl) begin
      cnt       <= '0;
      rx_sh     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_sh <= {rx_sh[W-2:0], mosi_lvl};
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[W-2:0], mosi_lvl};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_lvl) begin
      tx_sh <= '0;
      miso  <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_data;
    end else if (sck_fall) begin
      miso  <= tx_sh[W-1];
      tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/rtc_spi_ctrl.sv
`timescale 1ns/1ps
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lvl,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output phase_t            phase,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              tx_load
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (cs_lvl && byte_done) begin
      if (phase == PH_CMD) reg_addr <= rx_byte[ADDR_W-1:0];
      else if (phase != PH_SKIP) reg_addr <= ptr;
      if (phase == PH_WR) reg_wdata <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_lvl) begin
      phase   <= PH_CMD;
      ptr     <= '0;
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      tx_load <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      reg_re  <= 1'b0;
      tx_load <= reg_re;
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            if (!rx_byte[CMD_VALID]) begin
              phase <= PH_SKIP;
            end else if (rx_byte[CMD_READ]) begin
              phase  <= PH_RD;
              reg_re <= 1'b1;
              ptr    <= rx_byte[ADDR_W-1:0] + 1'b1;
            end else begin
              phase <= PH_WR;
              ptr   <= rx_byte[ADDR_W-1:0];
            end
          end
          PH_WR: begin
            reg_we <= 1'b1;
            ptr    <= ptr + 1'b1;
          end
          PH_RD: begin
            reg_re <= 1'b1;
            ptr    <= ptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_spi_target.sv
`timescale 1ns/1ps
module rtc_spi_target
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0]        pins_lvl;
  logic              cs_lvl, sck_lvl, mosi_lvl;
  logic              byte_done, tx_load;
  logic [DATA_W-1:0] rx_byte;
  phase_t            phase;

  rtc_spi_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_cs, spi_sck, spi_mosi}),
    .dout (pins_lvl)
  );
  assign {cs_lvl, sck_lvl, mosi_lvl} = pins_lvl;

  rtc_spi_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (cs_lvl),
    .sck_lvl   (sck_lvl),
    .mosi_lvl  (mosi_lvl),
    .tx_load   (tx_load),
    .tx_data   (reg_rdata),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  rtc_spi_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_lvl    (cs_lvl),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .phase     (phase),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .tx_load   (tx_load)
  );
endmodule

// File: rtl/rtc_spi_target_chk.sv
`timescale 1ns/1ps
module rtc_spi_target_chk
  import rtc_spi_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_lvl,
  input phase_t            phase,
  input logic              spi_miso,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re
);
  logic              had_we;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst || phase == PH_CMD) begin
      had_we    <= 1'b0;
      last_addr <= '0;
    end else if (reg_we) begin
      had_we    <= 1'b1;
      last_addr <= reg_addr;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));                                                // R3
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);                                                 // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (reg_we && had_we) |-> (reg_addr == ADDR_W'(last_addr + 1'b1)));     // R5
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> (!reg_we && !reg_re && !spi_miso));           // R6
  AST_CS_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> (!spi_miso && !reg_we && !reg_re));                      // R1
endmodule

bind rtc_spi_target rtc_spi_target_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_lvl   (cs_lvl),
  .phase    (phase),
  .spi_miso (spi_miso),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_re   (reg_re)
);

// File: tb/tb_rtc_spi_target.sv
`timescale 1ns/1ps
module tb_rtc_spi_target;
  localparam int HALF = 8;
  localparam int NV   = 9;
  // vector: {command[7:0], byte count[4:0], data seed[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {8'h12, 5'd7,  8'h30},   // write 7 from reg 2
    {8'h92, 5'd7,  8'h00},   // read 7 from reg 2
    {8'h19, 5'd4,  8'hC1},   // write 4 from reg 9
    {8'h99, 5'd4,  8'h00},   // read 4 from reg 9
    {8'h1E, 5'd4,  8'h5B},   // write crossing 15 -> 0
    {8'h9E, 5'd4,  8'h00},   // read crossing 15 -> 0
    {8'h02, 5'd3,  8'hEE},   // bit 4 clear: ignored
    {8'h8A, 5'd3,  8'h77},   // bit 7 set, bit 4 clear: ignored
    {8'h90, 5'd16, 8'h00}    // full read of all registers
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, sck = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic       miso, reg_we, reg_re;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, rdq;
  logic [7:0] rf [16];
  logic [7:0] mirror [16];
  int we_cnt, re_cnt, checks = 0, fails = 0;
  bit done = 1'b0;

  rtc_spi_target dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs(cs), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(rdq)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 29 + 7);
  endfunction

  // model of the clock core's register port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) rf[i] <= init_val(i);
      rdq <= '0; we_cnt <= 0; re_cnt <= 0;
    end else begin
      if (reg_we) begin rf[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
      if (reg_re) begin rdq <= rf[reg_addr]; re_cnt <= re_cnt + 1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      r[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic end_frame();
    wait_clk(HALF);
    cs = 1'b0;
    wait_clk(3 * HALF);
  endtask

  task automatic regs_match(input string req);
    bit ok = 1'b1;
    for (int i = 0; i < 16; i++) if (rf[i] !== mirror[i]) ok = 1'b0;
    check(ok, req, 0, 0);
  endtask

  task automatic run_vec(input logic [20:0] v);
    logic [7:0] cmd, seed, rx, d;
    int len, we0, re0;
    string req;
    cmd = v[20:13]; len = int'(v[12:8]); seed = v[7:0];
    req = (int'(cmd[3:0]) + len > 16) ? "R5" : (cmd[7] ? "R4" : "R3");
    we0 = we_cnt; re0 = re_cnt;
    cs = 1'b1;
    wait_clk(HALF);
    xfer(cmd, 8, rx);
    check(rx == 8'h00, "R9", rx, 0);
    for (int k = 0; k < len; k++) begin
      d = 8'(seed + k * 37);
      xfer(d, 8, rx);
      if (!cmd[4]) check(rx == 8'h00, "R6", rx, 0);
      else if (cmd[7]) check(rx == mirror[(cmd[3:0] + k) % 16], req, rx,
                             mirror[(cmd[3:0] + k) % 16]);
      else begin
        check(rx == 8'h00, "R9", rx, 0);
        mirror[(cmd[3:0] + k) % 16] = d;
      end
    end
    end_frame();
    if (!cmd[4]) begin
      check(we_cnt == we0 && re_cnt == re0, "R6", we_cnt - we0 + re_cnt - re0, 0);
      regs_match("R6");
    end else if (!cmd[7]) begin
      check(we_cnt - we0 == len, req, we_cnt - we0, len);
      regs_match(req);
    end
  endtask

  initial begin
    logic [7:0] rx;
    int we0;
    for (int i = 0; i < 16; i++) mirror[i] = init_val(i);
    wait_clk(5);
    // R8: reset state
    check(miso == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R8",
          {miso, reg_we, reg_re}, 0);
    rst = 1'b0;
    wait_clk(4);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R1: serial clock while chip select low does nothing
    we0 = we_cnt;
    xfer(8'h13, 8, rx);
    xfer(8'hFF, 8, rx);
    wait_clk(2 * HALF);
    check(we_cnt == we0 && rx == 8'h00, "R1", we_cnt - we0, 0);
    regs_match("R1");

    // R7: drop chip select in the middle of a data byte
    we0 = we_cnt;
    cs = 1'b1; wait_clk(HALF);
    xfer(8'h13, 8, rx);
    xfer(8'hA5, 8, rx);
    mirror[3] = 8'hA5;
    xfer(8'hFF, 4, rx);
    end_frame();
    check(we_cnt - we0 == 1, "R7", we_cnt - we0, 1);
    regs_match("R7");

    // R7: drop chip select in the middle of a command byte
    cs = 1'b1; wait_clk(HALF);
    xfer(8'h1F, 5, rx);
    end_frame();
    cs = 1'b1; wait_clk(HALF);
    xfer(8'h93, 8, rx);
    xfer(8'h00, 8, rx);
    check(rx == mirror[3], "R7", rx, mirror[3]);
    xfer(8'h00, 8, rx);
    check(rx == mirror[4], "R2", rx, mirror[4]);
    end_frame();
    check(miso == 1'b0, "R9", miso, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule